// File: doc/BRIEF.md
# Paged Open-Drain Port Bank

This block is the byte-wide host register front end for a bank of 48 digital lines, grouped as six 8-bit ports. Each line is an open-drain driver: a 1 in a port register turns on the line's current sink and pulls the pad low. A 0 releases the line to high impedance, where an external pull-up takes it high, so the same line can also serve as an input. There is no separate direction register. A released line is simply an input.

Reads of a port return the inverted pad level, after a two-flop synchronizer. A high pad therefore reads as 0, and a line the block is sinking itself reads as 1.

A single control byte at offset 0x07 has two fields. Bits 7:6 select one of four pages. Bits 5:0 are per-port write locks, with bit i locking port i. The page field remaps offsets 0x08 to 0x0A. On pages 1 to 3 these offsets reach three byte registers that belong to the selected page. On page 0 they are unused. The port offsets 0x00 to 0x05 behave the same on every page.

Top module: `pio_bank`

## Requirements
- R1: Reset (synchronous, active high) clears every port register, the control byte and all paged registers, so `sink_en` is all zero and offset 0x07 reads 0x00.
- R2: A write to offset p (0x00 to 0x05) on an unlocked port sets `sink_en[p*8+b]` to bit b of the written byte on the clock edge that takes the write; a 1 turns the sink on.
- R3: Writing 0 to a port bit turns that line's sink off, releasing it.
- R4: A read of offset p (0x00 to 0x05) returns the bitwise inverse of `pad_in[p*8+7 : p*8]` as seen through a two-flop synchronizer. `rdata` updates on the edge that samples `rd_en` and holds otherwise. A pad change first shows in a read sampled on the third rising edge after the change.
- R5: Port offsets 0x00 to 0x05 read and write identically whatever page is selected.
- R6: Offset 0x07 is the control byte, bits 7:6 the page number and bit i (i = 0 to 5) the lock of port i; it reads back the value last written.
- R7: On pages 1, 2 and 3, offsets 0x08, 0x09 and 0x0A reach nine distinct byte registers, three per page, each read back as written and untouched by writes on other pages.
- R8: On page 0, offsets 0x08 to 0x0A read 0x00 and writes to them change no paged register.
- R9: While port p's lock bit is 1, writes to offset p are ignored (`sink_en` for that port is unchanged), and reads of the port still return the pad state.
- R10: Offsets 0x06 and 0x0B to 0x0F read 0x00, and writes to them change no port, control or paged register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; `rdata` loads on this edge |
| rdata | output | 8 | Registered read data |
| pad_in | input | 48 | Pad levels, line n = port n/8, bit n%8 |
| sink_en | output | 48 | Per-line current sink enable (1 pulls the pad low) |

## Verification
A wrong port register shows on `sink_en` one edge after the write that corrupts it. If the control byte holds a wrong page, the next read of offsets 0x08 to 0x0A returns the wrong page's byte, or 0x00 instead of data. If it holds a wrong lock bit, a write is dropped or accepted against the lock, and `sink_en` shows this on the next edge. A synchronizer that has one stage too many or too few moves the cycle in which a pad change first reads back by one edge. The bench therefore samples reads exactly at the first, second and third edges after a pad change.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int PORT_W    = 8;
    localparam int NUM_PORTS = 6;
    localparam int PAGE_REGS = 3;
    localparam int NUM_PAGES = 4;
    localparam int ADDR_W    = 4;
    localparam int PAGE_W    = $clog2(NUM_PAGES);
    localparam int IDX_W     = 3;

    localparam logic [ADDR_W-1:0] CTRL_OFS  = 4'h7;
    localparam logic [ADDR_W-1:0] PAGE_BASE = 4'h8;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_PORT,
        SEL_CTRL,
        SEL_PAGE
    } sel_e;

    // control byte: page number on top, one lock bit per port below
    typedef struct packed {
        logic [PAGE_W-1:0]    page;
        logic [NUM_PORTS-1:0] lock;
    } ctrl_t;

    typedef struct packed {
        sel_e             kind;
        logic [IDX_W-1:0] idx;
    } dec_t;

    function automatic dec_t decode(input logic [ADDR_W-1:0] a,
                                    input logic [PAGE_W-1:0] pg);
        dec_t d;
        d.kind = SEL_NONE;
        d.idx  = '0;
        if (a < ADDR_W'(NUM_PORTS)) begin
            d.kind = SEL_PORT;
            d.idx  = a[IDX_W-1:0];
        end else if (a == CTRL_OFS) begin
            d.kind = SEL_CTRL;
        end else if (a >= PAGE_BASE && a < PAGE_BASE + ADDR_W'(PAGE_REGS)
                     && pg != '0) begin
            d.kind = SEL_PAGE;
            d.idx  = IDX_W'(a - PAGE_BASE);
        end
        return d;
    endfunction

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/pio_port_regs.sv
module pio_port_regs #(
    parameter int NP = 6,
    parameter int W  = 8,
    parameter int IW = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [IW-1:0]   idx,
    input  logic [NP-1:0]   lock,
    input  logic [W-1:0]    wdata,
    output logic [NP*W-1:0] sink
);
    for (genvar i = 0; i < NP; i++) begin : g_port
        logic [W-1:0] q;

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (we && idx == IW'(i) && !lock[i]) begin
                q <= wdata;
            end
        end

        assign sink[i*W +: W] = q;
    end
endmodule

// File: rtl/pio_page_regs.sv
module pio_page_regs #(
    parameter int NPG = 3,
    parameter int NR  = 3,
    parameter int W   = 8,
    parameter int PW  = 2,
    parameter int IW  = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [PW-1:0] page,
    input  logic [IW-1:0] idx,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rd_val
);
    // entry [p][r] belongs to page p+1; page 0 has no storage
    logic [W-1:0] mem [NPG][NR];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NPG; p++) begin
                for (int r = 0; r < NR; r++) begin
                    mem[p][r] <= '0;
                end
            end
        end else if (we) begin
            for (int p = 0; p < NPG; p++) begin
                for (int r = 0; r < NR; r++) begin
                    if (page == PW'(p + 1) && idx == IW'(r)) begin
                        mem[p][r] <= wdata;
                    end
                end
            end
        end
    end

    always_comb begin
        rd_val = '0;
        for (int p = 0; p < NPG; p++) begin
            for (int r = 0; r < NR; r++) begin
                if (page == PW'(p + 1) && idx == IW'(r)) begin
                    rd_val = mem[p][r];
                end
            end
        end
    end
endmodule

// File: rtl/pio_bank.sv
module pio_bank
    import pio_pkg::*;
#(
    parameter int NUM_PORTS = pio_pkg::NUM_PORTS,
    parameter int PORT_W    = pio_pkg::PORT_W,
    localparam int LINES    = NUM_PORTS * PORT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PORT_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [PORT_W-1:0] rdata,
    input  logic [LINES-1:0]  pad_in,
    output logic [LINES-1:0]  sink_en
);
    ctrl_t              ctrl_q;
    dec_t               dec;
    logic [LINES-1:0]   pad_s;
    logic [PORT_W-1:0]  page_rd;
    logic [PORT_W-1:0]  rd_val;

    assign dec = decode(addr, ctrl_q.page);

    pio_sync #(.W(LINES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pad_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en && dec.kind == SEL_CTRL) begin
            ctrl_q <= ctrl_t'(wdata);
        end
    end

    pio_port_regs #(.NP(NUM_PORTS), .W(PORT_W), .IW(IDX_W)) i_ports (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en && dec.kind == SEL_PORT),
        .idx   (dec.idx),
        .lock  (ctrl_q.lock),
        .wdata (wdata),
        .sink  (sink_en)
    );

    pio_page_regs #(
        .NPG (NUM_PAGES - 1),
        .NR  (PAGE_REGS),
        .W   (PORT_W),
        .PW  (PAGE_W),
        .IW  (IDX_W)
    ) i_pages (
        .clk    (clk),
        .rst    (rst),
        .we     (wr_en && dec.kind == SEL_PAGE),
        .page   (ctrl_q.page),
        .idx    (dec.idx),
        .wdata  (wdata),
        .rd_val (page_rd)
    );

    always_comb begin
        rd_val = '0;
        case (dec.kind)
            SEL_PORT: begin
                for (int i = 0; i < NUM_PORTS; i++) begin
                    if (dec.idx == IDX_W'(i)) begin
                        rd_val = ~pad_s[i*PORT_W +: PORT_W];
                    end
                end
            end
            SEL_CTRL: rd_val = ctrl_q;
            SEL_PAGE: rd_val = page_rd;
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_val;
        end
    end
endmodule

// File: rtl/pio_bank_chk.sv
module pio_bank_chk #(
    parameter int NUM_PORTS = 6,
    parameter int PORT_W    = 8
) (
    input logic                        clk,
    input logic                        rst,
    input logic [3:0]                  addr,
    input logic [PORT_W-1:0]           wdata,
    input logic                        wr_en,
    input logic                        rd_en,
    input logic [PORT_W-1:0]           rdata,
    input logic [NUM_PORTS*PORT_W-1:0] sink_en,
    input logic [7:0]                  ctrl_q,
    input logic [NUM_PORTS*PORT_W-1:0] pad_s
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> sink_en == '0);

    // R6
    ctrl_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 4'h7) |=> ctrl_q == $past(wdata));

    // R10
    unused_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (addr == 4'h6 || addr > 4'hA)) |=> rdata == '0);

    // R8
    page0_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr >= 4'h8 && addr <= 4'hA && ctrl_q[7:6] == 2'b00)
        |=> rdata == '0);

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chk
        // R2
        port_write_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && addr == 4'(i) && !ctrl_q[i])
            |=> sink_en[i*PORT_W +: PORT_W] == $past(wdata));

        // R9
        port_lock_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && addr == 4'(i) && ctrl_q[i])
            |=> $stable(sink_en[i*PORT_W +: PORT_W]));

        // R4
        port_read_chk: assert property (@(posedge clk) disable iff (rst)
            (rd_en && addr == 4'(i))
            |=> rdata == ~$past(pad_s[i*PORT_W +: PORT_W]));
    end
endmodule

bind pio_bank pio_bank_chk #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W)
) i_chk (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .wdata   (wdata),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rdata   (rdata),
    .sink_en (sink_en),
    .ctrl_q  (ctrl_q),
    .pad_s   (pad_s)
);

// File: tb/test_pio_bank.sv
module test_pio_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rdata;
    logic [47:0] pad_in;
    logic [47:0] sink_en;
    logic [47:0] ext_low = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    // open-drain pads with pull-ups: low when sunk here or pulled low outside
    assign pad_in = ~sink_en & ~ext_low;

    pio_bank i_pio_bank (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wdata   (wdata),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .rdata   (rdata),
        .pad_in  (pad_in),
        .sink_en (sink_en)
    );

    // entry: {write, req, addr, data, expected read}
    localparam int NVEC = 37;
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b1, 4'd2,  4'h0, 8'hA5, 8'h00},  // R2
        {1'b0, 4'd4,  4'h0, 8'h00, 8'hA5},  // R4
        {1'b1, 4'd2,  4'h5, 8'h3C, 8'h00},
        {1'b0, 4'd4,  4'h5, 8'h00, 8'h3C},
        {1'b1, 4'd3,  4'h0, 8'h00, 8'h00},  // R3
        {1'b0, 4'd3,  4'h0, 8'h00, 8'h00},
        {1'b1, 4'd6,  4'h7, 8'h40, 8'h00},  // R6
        {1'b0, 4'd6,  4'h7, 8'h00, 8'h40},
        {1'b1, 4'd7,  4'h8, 8'h11, 8'h00},  // R7 page 1
        {1'b1, 4'd7,  4'h9, 8'h22, 8'h00},
        {1'b1, 4'd7,  4'hA, 8'h33, 8'h00},
        {1'b0, 4'd7,  4'h8, 8'h00, 8'h11},
        {1'b0, 4'd7,  4'hA, 8'h00, 8'h33},
        {1'b1, 4'd7,  4'h7, 8'h80, 8'h00},  // page 2
        {1'b1, 4'd7,  4'h8, 8'h44, 8'h00},
        {1'b0, 4'd7,  4'h8, 8'h00, 8'h44},
        {1'b0, 4'd7,  4'h9, 8'h00, 8'h00},
        {1'b1, 4'd7,  4'h7, 8'hC0, 8'h00},  // page 3
        {1'b1, 4'd7,  4'hA, 8'h66, 8'h00},
        {1'b0, 4'd7,  4'hA, 8'h00, 8'h66},
        {1'b1, 4'd7,  4'h7, 8'h40, 8'h00},  // back to page 1
        {1'b0, 4'd7,  4'h9, 8'h00, 8'h22},
        {1'b0, 4'd5,  4'h5, 8'h00, 8'h3C},  // R5
        {1'b1, 4'd5,  4'h2, 8'h5A, 8'h00},
        {1'b0, 4'd5,  4'h2, 8'h00, 8'h5A},
        {1'b1, 4'd8,  4'h7, 8'h00, 8'h00},  // R8 page 0
        {1'b1, 4'd8,  4'h8, 8'hFF, 8'h00},
        {1'b0, 4'd8,  4'h8, 8'h00, 8'h00},
        {1'b1, 4'd8,  4'h7, 8'h40, 8'h00},
        {1'b0, 4'd8,  4'h8, 8'h00, 8'h11},
        {1'b0, 4'd10, 4'h6, 8'h00, 8'h00},  // R10
        {1'b1, 4'd10, 4'hF, 8'h55, 8'h00},
        {1'b0, 4'd10, 4'hF, 8'h00, 8'h00},
        {1'b1, 4'd10, 4'hB, 8'h77, 8'h00},
        {1'b0, 4'd10, 4'hB, 8'h00, 8'h00},
        {1'b1, 4'd10, 4'h6, 8'hAA, 8'h00},
        {1'b0, 4'd10, 4'h6, 8'h00, 8'h00}
    };

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
        end
    end

    initial begin
        logic [7:0] v;
        idle(3);
        rst = 1'b0;
        idle(3);
        // R1 reset state
        chk("R1 sink", sink_en, 48'h0);
        bus_read(4'h7, v);
        chk("R1 ctrl", {40'h0, v}, 48'h0);
        bus_read(4'h0, v);
        chk("R4 released pads read 0", {40'h0, v}, 48'h0);

        for (int k = 0; k < NVEC; k++) begin
            logic [24:0] e;
            e = VEC[k];
            if (e[24]) begin
                bus_write(e[19:16], e[15:8]);
            end else begin
                bus_read(e[19:16], v);
                chk($sformatf("R%0d vec%0d", e[23:20], k), {40'h0, v}, {40'h0, e[7:0]});
            end
            idle(3);
        end

        // R10 ignored writes left ports intact: port5=3C, port2=5A
        chk("R10 sink intact", sink_en, 48'h3C00_005A_0000);

        // R4 synchronizer latency: port 3 pulled low outside
        ext_low[31:24] = 8'hFF;
        bus_read(4'h3, v);
        chk("R4 edge1", {40'h0, v}, 48'h0);
        bus_read(4'h3, v);
        chk("R4 edge2", {40'h0, v}, 48'h0);
        bus_read(4'h3, v);
        chk("R4 edge3", {40'h0, v}, 48'hFF);
        ext_low = '0;
        idle(3);

        // R2 line mapping: port 3 bit 7 is line 31
        bus_write(4'h3, 8'h80);
        chk("R2 line31", {47'h0, sink_en[31]}, 48'h1);
        chk("R2 port3 low bits", {41'h0, sink_en[30:24]}, 48'h0);

        // R9 lock port 3 (page 1 kept)
        bus_write(4'h7, 8'h48);
        bus_write(4'h3, 8'h00);
        chk("R9 locked port held", {40'h0, sink_en[31:24]}, 48'h80);
        idle(3);
        bus_read(4'h3, v);
        chk("R9 locked port reads", {40'h0, v}, 48'h80);
        bus_write(4'h4, 8'h0F);
        chk("R9 unlocked port written", {40'h0, sink_en[39:32]}, 48'h0F);
        bus_write(4'h7, 8'h40);
        bus_write(4'h3, 8'h00);
        chk("R9 unlocked again", {40'h0, sink_en[31:24]}, 48'h0);

        // R1 reset mid-run clears everything
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        chk("R1 sink after reset", sink_en, 48'h0);
        bus_read(4'h7, v);
        chk("R1 ctrl after reset", {40'h0, v}, 48'h0);
        bus_write(4'h7, 8'h40);
        bus_read(4'h8, v);
        chk("R1 paged cleared", {40'h0, v}, 48'h0);

        done = 1;
        summary();
    end
endmodule